// File: doc/BRIEF.md
# Dual-Port Mailbox RAM with Collision Arbitration

This block is a 1024-word by 8-bit memory with two independent ports, called left and right. Each port has its own address, write data, enable, write enable and output enable. Both ports can reach every word, and both are sampled on one shared clock. A read returns data one cycle after the address, with a valid flag. A port whose enable is low is idle and has no effect on the block.

When both enabled ports present the same address, the block gives the word to one of them. The port that already held that address in the previous cycle wins. If both ports arrive in the same cycle, the left port wins. The loser sees its BUSY output high in the same cycle, and its write is dropped. A strap input selects master or slave behaviour. In slave mode the BUSY outputs stay low, and each port's write is inhibited by an external BUSY input instead. Several instances can then share the master's decision to form a wider word.

The two top addresses are mailboxes. A write by one port to its mailbox raises an interrupt flag toward the other port. A read of that mailbox by the receiving port clears the flag.

Top module: `dp_mailbox_ram`

## Requirements
- R1: A write by an enabled port (enable 1, write enable 1) stores the data at its address at the clock edge. A read (enable 1, write enable 0, output enable 1) by either port returns the stored word on that port's read data in the cycle after the address is presented, with read valid 1.
- R2: When a port makes no read in a cycle (enable 0, write enable 1, or output enable 0), its read data is 0 and its read valid is 0 in the next cycle.
- R3: A port with enable 0 writes nothing, whatever its write enable, address and data are.
- R4: In master mode (isMaster 1), suppose both ports are enabled on the same address and one port also held that address, with enable 1, in the previous cycle while the other did not. Then BUSY goes high on the other port, in the same cycle, and stays low on the holder.
- R5: In master mode, if both ports reach a common address in the same cycle, the left port wins and rBusyOut is high. While both ports stay on that address, ownership does not change.
- R6: In master mode, a write from the port whose BUSY is high is dropped. A read from that port still returns the stored word.
- R7: An unblocked write by the right port to address 0x3FF sets lIrq on the next cycle. A read of 0x3FF by the left port clears it. A write by the left port to 0x3FF, or a read of it by the right port, leaves lIrq unchanged.
- R8: An unblocked write by the left port to address 0x3FE sets rIrq on the next cycle. A read of 0x3FE by the right port clears it. A read of 0x3FE by the left port leaves rIrq unchanged.
- R9: In slave mode (isMaster 0), lBusyOut and rBusyOut stay 0. A write from a port whose BUSY input is 1 is dropped, and a write from a port whose BUSY input is 0 is stored even on a shared address.
- R10: A synchronous reset (rst 1 at a clock edge) clears both interrupt flags, both read valid flags, the read data and the arbitration history. After reset, a port present before the reset counts as newly arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset, active high |
| isMaster | input | 1 | 1: internal arbitration drives BUSY; 0: BUSY inputs inhibit writes |
| lEn | input | 1 | Left port enable |
| lWe | input | 1 | Left port write enable |
| lOe | input | 1 | Left port output enable |
| lAddr | input | 10 | Left port address |
| lWrData | input | 8 | Left port write data |
| lRdData | output | 8 | Left port read data, one cycle after the address |
| lRdValid | output | 1 | Left read data valid |
| lBusyIn | input | 1 | External BUSY for the left port (slave mode) |
| lBusyOut | output | 1 | Left port lost arbitration (master mode) |
| lIrq | output | 1 | Left mailbox interrupt flag |
| rEn | input | 1 | Right port enable |
| rWe | input | 1 | Right port write enable |
| rOe | input | 1 | Right port output enable |
| rAddr | input | 10 | Right port address |
| rWrData | input | 8 | Right port write data |
| rRdData | output | 8 | Right port read data, one cycle after the address |
| rRdValid | output | 1 | Right read data valid |
| rBusyIn | input | 1 | External BUSY for the right port (slave mode) |
| rBusyOut | output | 1 | Right port lost arbitration (master mode) |
| rIrq | output | 1 | Right mailbox interrupt flag |

## Verification
The hardest case to reach from the ports is a change of ownership on one address. One port must hold the word and win, then step away while the other stays. When it comes back, the stayer must now hold priority. The stimulus builds this cycle by cycle: a same-cycle arrival, a held pair, a departure and a return. BUSY is sampled after each change of inputs and before the next edge. A dropped write is then shown by reading the word back through the normal read path. The reset that clears the history is tested the same way: a port stays on its address across the reset edge, and the bench checks that it has lost its earlier claim.

// File: rtl/dp_mailbox_pkg.sv
package dp_mailbox_pkg;
  // Strobes from the control block to the storage datapath
  typedef struct packed {
    logic lWr;
    logic rWr;
    logic lRd;
    logic rRd;
  } ramStrobes_t;
endpackage

// File: rtl/dp_mailbox_ctrl.sv
module dp_mailbox_ctrl
  import dp_mailbox_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              isMaster,
  input  logic              lEn,
  input  logic              lWe,
  input  logic              lOe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lBusyIn,
  input  logic              rEn,
  input  logic              rWe,
  input  logic              rOe,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rBusyIn,
  output logic              lBusyOut,
  output logic              rBusyOut,
  output logic              lIrq,
  output logic              rIrq,
  output ramStrobes_t       stb
);
  localparam logic [ADDR_W-1:0] L_BOX = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] R_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};

  // Arbitration history
  logic              lEnQ, rEnQ, ownerQ;
  logic [ADDR_W-1:0] lAddrQ, rAddrQ;

  logic match, lHeld, rHeld, ownerRight;
  logic lArbBusy, rArbBusy, lBlock, rBlock;
  logic lIrqSet, lIrqClr, rIrqSet, rIrqClr;

  always_comb begin
    match      = lEn && rEn && (lAddr == rAddr);
    lHeld      = lEnQ && (lAddrQ == lAddr);
    rHeld      = rEnQ && (rAddrQ == rAddr);
    // both held: keep last decision; otherwise the earlier holder wins, left on a tie
    ownerRight = (lHeld && rHeld) ? ownerQ : (rHeld && !lHeld);
    lArbBusy   = match && ownerRight;
    rArbBusy   = match && !ownerRight;
    lBlock     = isMaster ? lArbBusy : lBusyIn;
    rBlock     = isMaster ? rArbBusy : rBusyIn;
    lBusyOut   = isMaster && lArbBusy;
    rBusyOut   = isMaster && rArbBusy;
    stb.lWr    = lEn && lWe && !lBlock;
    stb.rWr    = rEn && rWe && !rBlock;
    stb.lRd    = lEn && !lWe && lOe;
    stb.rRd    = rEn && !rWe && rOe;
    lIrqSet    = stb.rWr && (rAddr == L_BOX);
    lIrqClr    = stb.lRd && (lAddr == L_BOX);
    rIrqSet    = stb.lWr && (lAddr == R_BOX);
    rIrqClr    = stb.rRd && (rAddr == R_BOX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lEnQ   <= 1'b0;
      rEnQ   <= 1'b0;
      lAddrQ <= '0;
      rAddrQ <= '0;
      ownerQ <= 1'b0;
      lIrq   <= 1'b0;
      rIrq   <= 1'b0;
    end else begin
      lEnQ   <= lEn;
      rEnQ   <= rEn;
      lAddrQ <= lAddr;
      rAddrQ <= rAddr;
      ownerQ <= ownerRight;
      if (lIrqSet)      lIrq <= 1'b1;
      else if (lIrqClr) lIrq <= 1'b0;
      if (rIrqSet)      rIrq <= 1'b1;
      else if (rIrqClr) rIrq <= 1'b0;
    end
  end

  // R4
  busy_on_collision_chk: assert property (@(posedge clk) disable iff (rst)
    (lBusyOut || rBusyOut) |-> (isMaster && lEn && rEn && lAddr == rAddr));

  // R5
  owner_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lBusyOut) && lEn && rEn && lAddr == rAddr &&
     lAddr == $past(lAddr) && rAddr == $past(rAddr)) |-> lBusyOut);

  // R6
  no_double_write_chk: assert property (@(posedge clk) disable iff (rst)
    (isMaster && stb.lWr && stb.rWr) |-> (lAddr != rAddr));

  // R7
  lirq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(lIrq)) |-> $past(rEn && rWe && rAddr == L_BOX));

  // R7
  lirq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(lIrq)) |-> $past(lEn && !lWe && lOe && lAddr == L_BOX));

  // R8
  rirq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(rIrq)) |-> $past(lEn && lWe && lAddr == R_BOX));

  // R9
  slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !isMaster |-> (!lBusyOut && !rBusyOut));
endmodule

// File: rtl/dp_mailbox_dpath.sv
module dp_mailbox_dpath
  import dp_mailbox_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ramStrobes_t       stb,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] lWrData,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic              lRdValid,
  output logic [DATA_W-1:0] rRdData,
  output logic              rRdValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // storage has no reset; the right write lands last when both hit one word
  always_ff @(posedge clk) begin
    if (stb.lWr) mem[lAddr] <= lWrData;
    if (stb.rWr) mem[rAddr] <= rWrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lRdData  <= '0;
      lRdValid <= 1'b0;
      rRdData  <= '0;
      rRdValid <= 1'b0;
    end else begin
      lRdValid <= stb.lRd;
      rRdValid <= stb.rRd;
      lRdData  <= stb.lRd ? mem[lAddr] : '0;
      rRdData  <= stb.rRd ? mem[rAddr] : '0;
    end
  end

  // R2
  lrd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !lRdValid |-> (lRdData == '0));

  // R2
  rrd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rRdValid |-> (rRdData == '0));
endmodule

// File: rtl/dp_mailbox_ram.sv
module dp_mailbox_ram
  import dp_mailbox_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              isMaster,
  input  logic              lEn,
  input  logic              lWe,
  input  logic              lOe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic              lRdValid,
  input  logic              lBusyIn,
  output logic              lBusyOut,
  output logic              lIrq,
  input  logic              rEn,
  input  logic              rWe,
  input  logic              rOe,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData,
  output logic              rRdValid,
  input  logic              rBusyIn,
  output logic              rBusyOut,
  output logic              rIrq
);
  ramStrobes_t stb;

  dp_mailbox_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .isMaster(isMaster),
    .lEn(lEn), .lWe(lWe), .lOe(lOe), .lAddr(lAddr), .lBusyIn(lBusyIn),
    .rEn(rEn), .rWe(rWe), .rOe(rOe), .rAddr(rAddr), .rBusyIn(rBusyIn),
    .lBusyOut(lBusyOut), .rBusyOut(rBusyOut),
    .lIrq(lIrq), .rIrq(rIrq), .stb(stb)
  );

  dp_mailbox_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rst(rst), .stb(stb),
    .lAddr(lAddr), .rAddr(rAddr), .lWrData(lWrData), .rWrData(rWrData),
    .lRdData(lRdData), .lRdValid(lRdValid),
    .rRdData(rRdData), .rRdValid(rRdValid)
  );
endmodule

// File: tb/dp_mailbox_ram_tb_top.sv
`timescale 1ns/1ps
module dp_mailbox_ram_tb_top;
  logic clk = 1'b0;
  logic rst, isMaster;
  logic lEn, lWe, lOe, lBusyIn, rEn, rWe, rOe, rBusyIn;
  logic [9:0] lAddr, rAddr;
  logic [7:0] lWrData, rWrData;
  logic [7:0] lRdData, rRdData;
  logic lRdValid, rRdValid, lBusyOut, rBusyOut, lIrq, rIrq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dp_mailbox_ram dut_i (
    .clk(clk), .rst(rst), .isMaster(isMaster),
    .lEn(lEn), .lWe(lWe), .lOe(lOe), .lAddr(lAddr), .lWrData(lWrData),
    .lRdData(lRdData), .lRdValid(lRdValid), .lBusyIn(lBusyIn),
    .lBusyOut(lBusyOut), .lIrq(lIrq),
    .rEn(rEn), .rWe(rWe), .rOe(rOe), .rAddr(rAddr), .rWrData(rWrData),
    .rRdData(rRdData), .rRdValid(rRdValid), .rBusyIn(rBusyIn),
    .rBusyOut(rBusyOut), .rIrq(rIrq)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    lEn = 0; lWe = 0; lOe = 0; lAddr = '0; lWrData = '0; lBusyIn = 0;
    rEn = 0; rWe = 0; rOe = 0; rAddr = '0; rWrData = '0; rBusyIn = 0;
  endtask

  task automatic lWr(logic [9:0] a, logic [7:0] d);
    lEn = 1; lWe = 1; lOe = 0; lAddr = a; lWrData = d;
  endtask
  task automatic rWr(logic [9:0] a, logic [7:0] d);
    rEn = 1; rWe = 1; rOe = 0; rAddr = a; rWrData = d;
  endtask
  task automatic lRd(logic [9:0] a);
    lEn = 1; lWe = 0; lOe = 1; lAddr = a;
  endtask
  task automatic rRd(logic [9:0] a);
    rEn = 1; rWe = 0; rOe = 1; rAddr = a;
  endtask

  task automatic t_reset();
    chk("R10 lIrq after reset", lIrq, 0);
    chk("R10 rIrq after reset", rIrq, 0);
    chk("R10 lRdValid after reset", lRdValid, 0);
    chk("R10 rRdData after reset", rRdData, 0);
  endtask

  task automatic t_basic();
    idle(); lWr(10'd5, 8'hA5); tick();
    idle(); rRd(10'd5); tick();
    chk("R1 right reads left write", rRdData, 8'hA5);
    chk("R1 right valid", rRdValid, 1);
    idle(); rWr(10'd6, 8'h3C); tick();
    idle(); lRd(10'd6); tick();
    chk("R1 left reads right write", lRdData, 8'h3C);
    chk("R1 left valid", lRdValid, 1);
  endtask

  task automatic t_noread();
    idle(); rEn = 1; rAddr = 10'd5; rOe = 0; tick();
    chk("R2 oe low data", rRdData, 0);
    chk("R2 oe low valid", rRdValid, 0);
    idle(); lEn = 0; lOe = 1; lAddr = 10'd5; tick();
    chk("R2 disabled valid", lRdValid, 0);
    chk("R2 disabled data", lRdData, 0);
  endtask

  task automatic t_disabled();
    idle(); rEn = 0; rWe = 1; rAddr = 10'd5; rWrData = 8'hFF; tick();
    idle(); lRd(10'd5); tick();
    chk("R3 disabled port wrote nothing", lRdData, 8'hA5);
  endtask

  task automatic t_held();
    idle(); lWr(10'd20, 8'h44); tick();
    idle(); lRd(10'd20); tick();
    rWr(10'd20, 8'h99); #1;
    chk("R4 late right busy", rBusyOut, 1);
    chk("R4 holder left not busy", lBusyOut, 0);
    tick();
    chk("R4 holder left read", lRdData, 8'h44);
    rRd(10'd20); #1;
    chk("R6 loser still busy", rBusyOut, 1);
    tick();
    chk("R6 blocked write kept old word", rRdData, 8'h44);
    chk("R6 loser read valid", rRdValid, 1);
    idle(); rWr(10'd30, 8'h55); tick();
    idle(); rRd(10'd30); tick();
    lWr(10'd30, 8'h77); #1;
    chk("R4 late left busy", lBusyOut, 1);
    chk("R4 holder right not busy", rBusyOut, 0);
    tick();
    idle(); lRd(10'd30); tick();
    chk("R6 left blocked write", lRdData, 8'h55);
  endtask

  task automatic t_tie();
    idle(); tick();
    lWr(10'd40, 8'h11); rWr(10'd40, 8'h22); #1;
    chk("R5 tie right busy", rBusyOut, 1);
    chk("R5 tie left not busy", lBusyOut, 0);
    tick(); #1;
    chk("R5 ownership kept", rBusyOut, 1);
    tick();
    lEn = 0; lWe = 0; rRd(10'd40); tick();
    chk("R5 winner data stored", rRdData, 8'h11);
    lRd(10'd40); #1;
    chk("R5 returning left now busy", lBusyOut, 1);
    chk("R5 stayer right not busy", rBusyOut, 0);
    tick();
    chk("R6 busy left reads stored", lRdData, 8'h11);
    idle(); tick();
  endtask

  task automatic t_mailbox();
    idle(); rWr(10'h3FF, 8'h5A); tick();
    chk("R7 lIrq set", lIrq, 1);
    chk("R8 rIrq untouched", rIrq, 0);
    idle(); rRd(10'h3FF); tick();
    chk("R7 right read keeps lIrq", lIrq, 1);
    idle(); lRd(10'h3FF); tick();
    chk("R7 left mailbox data", lRdData, 8'h5A);
    chk("R7 lIrq cleared", lIrq, 0);
    idle(); lWr(10'h3FF, 8'h01); tick();
    chk("R7 left write own box no irq", lIrq, 0);
    idle(); lWr(10'h3FE, 8'hC3); tick();
    chk("R8 rIrq set", rIrq, 1);
    chk("R7 lIrq untouched", lIrq, 0);
    idle(); lRd(10'h3FE); tick();
    chk("R8 left read keeps rIrq", rIrq, 1);
    idle(); rRd(10'h3FE); tick();
    chk("R8 rIrq cleared", rIrq, 0);
    chk("R8 right mailbox data", rRdData, 8'hC3);
  endtask

  task automatic t_slave();
    isMaster = 0;
    idle(); lRd(10'd40); rRd(10'd40); #1;
    chk("R9 slave lBusyOut low", lBusyOut, 0);
    chk("R9 slave rBusyOut low", rBusyOut, 0);
    tick();
    idle(); lWr(10'd50, 8'hAB); tick();
    idle(); lWr(10'd50, 8'h12); lBusyIn = 1; tick();
    idle(); lRd(10'd50); tick();
    chk("R9 busy input inhibits write", lRdData, 8'hAB);
    idle(); lWr(10'd60, 8'h01); rWr(10'd60, 8'h02); rBusyIn = 1; tick();
    idle(); rRd(10'd60); tick();
    chk("R9 unbusy shared write stored", rRdData, 8'h01);
    idle(); isMaster = 1; tick();
  endtask

  task automatic t_reset_hist();
    idle(); rWr(10'h3FF, 8'h77); tick();
    idle(); rRd(10'd70); tick();
    rst = 1; tick();
    rst = 0;
    chk("R10 reset clears lIrq", lIrq, 0);
    chk("R10 reset clears rRdValid", rRdValid, 0);
    lRd(10'd70); #1;
    chk("R10 history cleared right busy", rBusyOut, 1);
    chk("R10 history cleared left free", lBusyOut, 0);
    tick();
    idle(); tick();
  endtask

  initial begin
    #(20 * 50000);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; isMaster = 1; idle();
    repeat (3) tick();
    rst = 0;
    t_reset();
    t_basic();
    t_noread();
    t_disabled();
    t_held();
    t_tie();
    t_mailbox();
    t_slave();
    t_reset_hist();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule